// File: doc/BRIEF.md
# Scanline FIFO Sampling Scheduler

This block paces how the display FIFO is drained during the visible part of each frame. When a scanline starts, it waits a fixed lead time and then steps once per group of eight pixels. At each step it can pulse a refill request to the DMA engine and issue a pop command to the FIFO storage. A pop command gives the pixel offset in the line buffer where the popped pixels land, and how many pixels to pop. The DMA engine and the FIFO storage are separate blocks.

Sampling begins a few pixels before active display, so the pops do not line up with the eight-pixel grid. The first pop is short, the middle pops are full eight-pixel chunks placed a lead distance behind the step position, and the line closes with a short tail pop. The whole mechanism runs only in frames that need it. That decision is latched at frame start from the display-mode field, the capture-control fields and an indication that a DMA channel is armed for display-FIFO refills.

Top module: `fifo_sample_sched`

## Requirements
- R1: While rst_ni is low, and after it rises until a line sequence starts, pop_o and dma_req_o are 0.
- R2: On a frame_start_i cycle the run enable is latched. It is 1 when disp_ctrl_i[17:16] == 3, or when cap_ctrl_i[25] == 1 with cap_ctrl_i[30:29] != 0, or when dma_armed_i == 1. All other bits of both words are ignored.
- R3: A line sequence starts only for a line_start_i cycle with line_num_i < LINES (default 192) and the run enable set. Its first step shows on the outputs START_DLY (default 32) clock edges after the edge that samples line_start_i.
- R4: Steps recur every STEP_CYC (default 48) edges. The step position x starts at 0 and grows by CHUNK (8) per step, up to and including x = LINE_PIX (256).
- R5: dma_req_o pulses at every step with x < LINE_PIX and not at the step with x = LINE_PIX.
- R6: The step at x = 0 issues no pop. The step at x = CHUNK pops CHUNK-PRE_PIX (5) pixels at offset 0.
- R7: Each step with CHUNK < x <= LINE_PIX pops CHUNK pixels at offset x-CHUNK-PRE_PIX (x-11).
- R8: One cycle after the step at x = LINE_PIX, a tail pop of PRE_PIX (3) pixels at offset LINE_PIX-PRE_PIX (253) is issued, and the line's sequence ends.
- R9: In a frame whose latched run enable is 0, no pop and no DMA request is issued on any line.
- R10: A line_start_i or frame_start_i cycle aborts any sequence in progress, including a pending tail pop. A line start then begins a fresh sequence under R3.
- R11: pop_o and dma_req_o are single-cycle pulses. Apart from the tail pop that directly follows the last step, no output is high two cycles running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame start strobe; latches the run enable |
| disp_ctrl_i | input | 32 | Display control word; bits 17:16 are the display mode |
| cap_ctrl_i | input | 32 | Capture control word; bit 25 enables capture, bits 30:29 select its source |
| dma_armed_i | input | 1 | A DMA channel is armed for display-FIFO refills |
| line_start_i | input | 1 | Scanline start strobe |
| line_num_i | input | LNW | Number of the line that is starting |
| pop_o | output | 1 | Pop command strobe |
| pop_off_o | output | OFFW | Line-buffer offset for the popped pixels |
| pop_cnt_o | output | CNTW | Number of pixels to pop |
| dma_req_o | output | 1 | DMA refill request pulse |

## Verification
Every output is registered once after the step decision. For a sequence whose line_start_i is sampled at edge E0, step k is visible right after edge E0+START_DLY+k·STEP_CYC, and the tail pop is visible one edge after the last step. The bench runs a reduced configuration. It computes this timetable from the parameters and compares all outputs after every rising edge, at the following falling edge, so both the pulses and the quiet cycles between them are checked. Aborts are placed so that a leftover step from the old sequence would land on a cycle where the new sequence expects silence.

// File: rtl/fifo_sched_pkg.sv
package fifo_sched_pkg;
  localparam int DMODE_LO   = 16;
  localparam int CAP_EN_BIT = 25;
  localparam int CAP_SRC_LO = 29;

  function automatic logic fifo_in_use(logic [31:0] disp, logic [31:0] cap, logic dma_armed);
    return (disp[DMODE_LO +: 2] == 2'd3) ||
           (cap[CAP_EN_BIT] && (cap[CAP_SRC_LO +: 2] != 2'd0)) ||
           dma_armed;
  endfunction
endpackage

// File: rtl/fifo_sched_gate.sv
module fifo_sched_gate
  import fifo_sched_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_start_i,
  input  logic [31:0] disp_ctrl_i,
  input  logic [31:0] cap_ctrl_i,
  input  logic        dma_armed_i,
  output logic        run_nxt_o,
  output logic        run_q_o
);
  logic run_q;

  // a line start in the frame-start cycle sees the new value
  assign run_nxt_o = frame_start_i ? fifo_in_use(disp_ctrl_i, cap_ctrl_i, dma_armed_i) : run_q;
  assign run_q_o   = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_nxt_o;
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> run_q == $past(run_q));
endmodule

// File: rtl/fifo_sched_timer.sv
module fifo_sched_timer #(
  parameter int START_DLY = 32,
  parameter int STEP_CYC  = 48,
  parameter int CHUNK     = 8,
  parameter int LINE_PIX  = 256,
  parameter int LINES     = 192,
  parameter int LNW       = 9,
  localparam int MAXW     = (START_DLY > STEP_CYC) ? START_DLY : STEP_CYC,
  localparam int WAITW    = $clog2(MAXW + 1),
  localparam int XW       = $clog2(LINE_PIX + CHUNK + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           line_start_i,
  input  logic [LNW-1:0] line_num_i,
  input  logic           run_i,
  input  logic           kill_i,
  output logic           step_o,
  output logic [XW-1:0]  x_o
);
  logic             active_q;
  logic [WAITW-1:0] wait_q;
  logic [XW-1:0]    x_q;
  logic             visible;

  assign visible = (int'(line_num_i) < LINES);
  assign step_o  = active_q && (wait_q == '0) && !line_start_i && !kill_i;
  assign x_o     = x_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wait_q   <= '0;
      x_q      <= '0;
    end else if (line_start_i) begin
      active_q <= run_i && visible;
      wait_q   <= WAITW'(START_DLY - 1);
      x_q      <= '0;
    end else if (kill_i) begin
      active_q <= 1'b0;
    end else if (step_o) begin
      x_q      <= x_q + XW'(CHUNK);
      wait_q   <= WAITW'(STEP_CYC - 1);
      if (x_q == XW'(LINE_PIX)) active_q <= 1'b0;
    end else if (active_q) begin
      wait_q   <= wait_q - 1'b1;
    end
  end

  a_r4_x_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> x_q <= XW'(LINE_PIX));
  a_r4_wait_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> wait_q < WAITW'(MAXW));
  a_r3_step_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> !$past(line_start_i) || $past(active_q) || START_DLY == 1);
endmodule

// File: rtl/fifo_sched_popgen.sv
module fifo_sched_popgen #(
  parameter int CHUNK    = 8,
  parameter int PRE_PIX  = 3,
  parameter int LINE_PIX = 256,
  localparam int XW      = $clog2(LINE_PIX + CHUNK + 1),
  localparam int OFFW    = $clog2(LINE_PIX),
  localparam int CNTW    = $clog2(CHUNK + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic [XW-1:0]   x_i,
  input  logic            abort_i,
  output logic            pop_o,
  output logic [OFFW-1:0] pop_off_o,
  output logic [CNTW-1:0] pop_cnt_o,
  output logic            dma_req_o
);
  logic            tail_q;
  logic [XW-1:0]   back;
  logic [OFFW-1:0] off_c;
  logic [CNTW-1:0] cnt_c;

  assign back = x_i - XW'(CHUNK + PRE_PIX);

  always_comb begin
    if (x_i == XW'(CHUNK)) begin
      off_c = '0;
      cnt_c = CNTW'(CHUNK - PRE_PIX);
    end else if (x_i == '0) begin
      off_c = '0;
      cnt_c = '0;
    end else begin
      off_c = back[OFFW-1:0];
      cnt_c = CNTW'(CHUNK);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_o     <= 1'b0;
      pop_off_o <= '0;
      pop_cnt_o <= '0;
      dma_req_o <= 1'b0;
      tail_q    <= 1'b0;
    end else begin
      pop_o     <= 1'b0;
      pop_off_o <= '0;
      pop_cnt_o <= '0;
      dma_req_o <= 1'b0;
      tail_q    <= 1'b0;
      if (abort_i) begin
        // pending tail dropped
      end else if (step_i) begin
        pop_o     <= (x_i != '0);
        pop_off_o <= off_c;
        pop_cnt_o <= cnt_c;
        dma_req_o <= (x_i < XW'(LINE_PIX));
        tail_q    <= (x_i == XW'(LINE_PIX));
      end else if (tail_q) begin
        pop_o     <= 1'b1;
        pop_off_o <= OFFW'(LINE_PIX - PRE_PIX);
        pop_cnt_o <= CNTW'(PRE_PIX);
      end
    end
  end

  a_r11_dma_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |=> !dma_req_o);
  a_r8_tail_after_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_q |-> pop_o && pop_cnt_o == CNTW'(CHUNK));
  a_r5_no_dma_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_q |-> !dma_req_o);
  a_r7_pop_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> (int'(pop_off_o) + int'(pop_cnt_o)) <= LINE_PIX);
endmodule

// File: rtl/fifo_sample_sched.sv
module fifo_sample_sched #(
  parameter int START_DLY = 32,
  parameter int STEP_CYC  = 48,
  parameter int CHUNK     = 8,
  parameter int PRE_PIX   = 3,
  parameter int LINE_PIX  = 256,
  parameter int LINES     = 192,
  parameter int LNW       = 9,
  localparam int XW       = $clog2(LINE_PIX + CHUNK + 1),
  localparam int OFFW     = $clog2(LINE_PIX),
  localparam int CNTW     = $clog2(CHUNK + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_start_i,
  input  logic [31:0]     disp_ctrl_i,
  input  logic [31:0]     cap_ctrl_i,
  input  logic            dma_armed_i,
  input  logic            line_start_i,
  input  logic [LNW-1:0]  line_num_i,
  output logic            pop_o,
  output logic [OFFW-1:0] pop_off_o,
  output logic [CNTW-1:0] pop_cnt_o,
  output logic            dma_req_o
);
  logic          run_nxt, run_q;
  logic          step;
  logic [XW-1:0] x;

  fifo_sched_gate u_gate (
    .clk_i, .rst_ni, .frame_start_i, .disp_ctrl_i, .cap_ctrl_i, .dma_armed_i,
    .run_nxt_o (run_nxt),
    .run_q_o   (run_q)
  );

  fifo_sched_timer #(
    .START_DLY(START_DLY), .STEP_CYC(STEP_CYC), .CHUNK(CHUNK),
    .LINE_PIX(LINE_PIX), .LINES(LINES), .LNW(LNW)
  ) u_timer (
    .clk_i, .rst_ni, .line_start_i, .line_num_i,
    .run_i  (run_nxt),
    .kill_i (frame_start_i),
    .step_o (step),
    .x_o    (x)
  );

  fifo_sched_popgen #(
    .CHUNK(CHUNK), .PRE_PIX(PRE_PIX), .LINE_PIX(LINE_PIX)
  ) u_popgen (
    .clk_i, .rst_ni,
    .step_i  (step),
    .x_i     (x),
    .abort_i (line_start_i || frame_start_i),
    .pop_o, .pop_off_o, .pop_cnt_o, .dma_req_o
  );

  a_r9_idle_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !$past(run_q)) |-> !pop_o && !dma_req_o);
endmodule

// File: tb/fifo_sample_sched_bench.sv
module fifo_sample_sched_bench;
  localparam int CLK_PER  = 10;
  localparam int START    = 4;
  localparam int STEP     = 6;
  localparam int CHUNK    = 8;
  localparam int PRE      = 3;
  localparam int LPIX     = 32;
  localparam int LINES    = 3;
  localparam int LNW      = 9;
  localparam int OFFW     = $clog2(LPIX);
  localparam int CNTW     = $clog2(CHUNK + 1);
  localparam int NSTEP    = LPIX / CHUNK;
  localparam int FULL     = START + STEP * NSTEP + 3;
  localparam int WD_LIMIT = 150000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frame_start = 1'b0;
  logic [31:0]     disp_ctrl = '0;
  logic [31:0]     cap_ctrl = '0;
  logic            dma_armed = 1'b0;
  logic            line_start = 1'b0;
  logic [LNW-1:0]  line_num = '0;
  logic            pop;
  logic [OFFW-1:0] pop_off;
  logic [CNTW-1:0] pop_cnt;
  logic            dma_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;

  fifo_sample_sched #(
    .START_DLY(START), .STEP_CYC(STEP), .CHUNK(CHUNK), .PRE_PIX(PRE),
    .LINE_PIX(LPIX), .LINES(LINES), .LNW(LNW)
  ) u_fifo_sample_sched (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start),
    .disp_ctrl_i(disp_ctrl), .cap_ctrl_i(cap_ctrl), .dma_armed_i(dma_armed),
    .line_start_i(line_start), .line_num_i(line_num),
    .pop_o(pop), .pop_off_o(pop_off), .pop_cnt_o(pop_cnt), .dma_req_o(dma_req)
  );

  task automatic check(input string tag, input bit ep, input bit ed,
                       input int eo, input int ec);
    bit ok;
    n_chk++;
    ok = (pop == ep) && (dma_req == ed);
    if (ep) ok = ok && (int'(pop_off) == eo) && (int'(pop_cnt) == ec);
    if (!ok) begin
      n_bad++;
      $display("FAIL %s t=%0t pop/dma/off/cnt actual %0b/%0b/%0d/%0d expected %0b/%0b/%0d/%0d",
               tag, $time, pop, dma_req, pop_off, pop_cnt, ep, ed, eo, ec);
    end
  endtask

  // latch run enable; outputs must be quiet in the frame-start cycle
  task automatic new_frame(input logic [31:0] d, input logic [31:0] c, input bit a);
    disp_ctrl = d; cap_ctrl = c; dma_armed = a; frame_start = 1'b1;
    @(posedge clk); #1; frame_start = 1'b0;
    @(negedge clk);
    check("R10 R2 frame start", 1'b0, 1'b0, 0, 0);
  endtask

  // start a line at the next edge and check ncyc edges after it
  task automatic run_line(input int ln, input bit en, input int ncyc, input string base);
    line_num = LNW'(ln); line_start = 1'b1;
    @(posedge clk); #1; line_start = 1'b0;
    @(negedge clk);
    check({base, " line start edge"}, 1'b0, 1'b0, 0, 0);
    for (int c = 1; c <= ncyc; c++) begin
      bit ep, ed; int eo, ec; string tag;
      @(posedge clk); @(negedge clk);
      ep = 1'b0; ed = 1'b0; eo = 0; ec = 0; tag = base;
      if (en && ln < LINES) begin
        if (c >= START && ((c - START) % STEP) == 0 && (c - START) / STEP <= NSTEP) begin
          int k, x;
          k = (c - START) / STEP; x = CHUNK * k;
          ed = (x < LPIX);
          ep = (k > 0);
          eo = (k == 1) ? 0 : x - CHUNK - PRE;
          ec = (k == 1) ? CHUNK - PRE : CHUNK;
          if (k == 0)          tag = "R3 R4 R5 first step";
          else if (k == 1)     tag = "R4 R5 R6 short first pop";
          else if (k == NSTEP) tag = "R4 R5 R7 last step";
          else                 tag = "R4 R5 R7 middle step";
        end else if (c == START + STEP * NSTEP + 1) begin
          ep = 1'b1; eo = LPIX - PRE; ec = PRE; tag = "R8 tail pop";
        end else if (c > START && ((c - START) % STEP) == 1) begin
          tag = "R11 after pulse";
        end
      end
      check(tag, ep, ed, eo, ec);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 1'b0, 0, 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", 1'b0, 1'b0, 0, 0);

    // run-enable decode sweep, noise in unrelated bits
    for (int m = 0; m < 4; m++)
      for (int ce = 0; ce < 2; ce++)
        for (int cs = 0; cs < 4; cs++)
          for (int da = 0; da < 2; da++) begin
            logic [31:0] d, c;
            bit en;
            d = 32'hFFFC_FFFF | (32'(m) << 16);
            c = 32'h9DFF_FFFF | (32'(ce) << 25) | (32'(cs) << 29);
            en = (m == 3) || (ce == 1 && cs != 0) || (da == 1);
            new_frame(d, c, da[0]);
            run_line(0, en, FULL, en ? "R2 enabled" : "R2 R9 disabled");
          end

    // line range in an enabled frame
    new_frame(32'h0003_0000, 32'h0, 1'b0);
    for (int ln = 0; ln < LINES + 2; ln++) run_line(ln, 1'b1, FULL, "R3 line range");
    run_line(255, 1'b1, FULL, "R3 high line");

    // disabled frame across all lines
    new_frame(32'h0002_0000, 32'h2000_0000, 1'b0);
    for (int ln = 0; ln < LINES; ln++) run_line(ln, 1'b0, FULL, "R9 idle frame");

    // aborts: mid-sequence, and exactly on the tail cycle
    new_frame(32'h0, 32'h0200_0000 | 32'h4000_0000, 1'b0);
    run_line(0, 1'b1, START + STEP * 1 + 3, "R10 before abort");
    run_line(1, 1'b1, FULL, "R10 after mid abort");
    run_line(2, 1'b1, START + STEP * NSTEP, "R10 before tail abort");
    run_line(0, 1'b1, FULL, "R10 after tail abort");

    // frame start kills a running line
    run_line(1, 1'b1, START + STEP * 2 + 2, "R10 before frame abort");
    new_frame(32'h0, 32'h0, 1'b1);
    for (int c = 0; c < STEP * NSTEP; c++) begin
      @(posedge clk); @(negedge clk);
      check("R10 after frame abort", 1'b0, 1'b0, 0, 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule